// File: doc/BRIEF.md
# Counter Snapshot Register Interface

This block sits between a byte-wide host bus and three 24-bit BCD position counters (channels X, Y and Z). The host issues a copy command, and the block then loads all three counter values into a holding store at a single clock edge. It only loads on a cycle where the counter logic reports no activity, so no value is captured half-updated. To read a value, the host writes a command byte that selects a channel and resets an internal pointer. Each later read of the control offset returns the next decimal digit of that channel, starting with the most significant digit. Selecting channel 0 returns a status byte instead, which carries the operator flag and the rate-error indication.

The same four-offset map also serves several other functions. It holds the operator LED drivers and the interrupt enable. It connects an 8-bit parallel input and an 8-bit latched parallel output. It gives access to a small scratch RAM, which the shared pointer walks one byte per access. A clear command pulses a clear output toward the counters and returns the command state to its reset value.

Top module: `snapshot_host_regs`

## Requirements
- R1: A write to offset 0 with bit 0 clear raises `cnt_clear_o` for exactly the next cycle. The same write zeroes the command state (LEDs off, interrupt enable off, status channel selected) and the pointer.
- R2: A write to offset 0 with bit 0 set, while `cnt_busy_i` is low, loads all three counters into the holding store at that edge. Later counter changes do not alter the values that are read back.
- R3: A write to offset 3 sets the command byte as follows. Bit 7 is the interrupt enable. Bits 6..3 drive `led_o[3..0]`. Bit 2 has no effect. Bits 1:0 select the channel: 01 is X, 10 is Y, 11 is Z and 00 is status. `irq_o` is high exactly when the flag is set and the enable is on.
- R4: With channel X, Y or Z selected, a read of offset 0 returns one digit in bits 3..0, with bits 7..4 zero. Successive reads return the 6 digits most significant first, and any read after the sixth returns 0x00.
- R5: With channel 00 selected, a read of offset 0 returns the status byte. Bit 7 is the switch flag, bit 6 is `rate_err_i`, bits 5..4 are zero and bits 3..0 are all ones.
- R6: The pointer returns to 0 on any command write and on the clear command. It advances by one on each digit read and on each read or write of offset 2. A status read does not advance it.
- R7: A read of offset 1 returns `par_in_i`. A write of offset 1 sets `par_out_o`, which holds its value until the next such write.
- R8: A pulse on `sw_event_i` sets the switch flag. A read of offset 3 returns 0xFF and clears the flag. If the flag is set and cleared in the same cycle, the flag stays set.
- R9: A copy request made while `cnt_busy_i` is high is held until the first cycle in which `cnt_busy_i` is low. The capture then takes the counter values of that cycle, and the request is never lost.
- R10: A write of offset 2 stores the byte in the scratch RAM at the pointer address. A read of offset 2 returns the byte stored at the pointer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 2 | Register offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the strobe cycle |
| cnt_x_i | input | 24 | Live BCD value of channel X |
| cnt_y_i | input | 24 | Live BCD value of channel Y |
| cnt_z_i | input | 24 | Live BCD value of channel Z |
| cnt_busy_i | input | 1 | Some counter is updating this cycle |
| rate_err_i | input | 1 | Rate-error level from the counters |
| sw_event_i | input | 1 | Debounced operator switch pulse |
| par_in_i | input | 8 | Parallel input lines |
| par_out_o | output | 8 | Latched parallel output |
| led_o | output | 4 | LED drivers |
| irq_o | output | 1 | Interrupt request |
| cnt_clear_o | output | 1 | One-cycle clear toward the counters |

## Verification
Two pairs of functions can collide in one cycle, and both are driven together on purpose. In the first, a copy request lands while `cnt_busy_i` is high, and the counter values change again before the busy signal drops. The digits read afterwards must match the values present in the first idle cycle, not the values at the time of the request or the previous snapshot. In the second, a switch pulse and a flag-clearing read of offset 3 arrive in the same cycle. The status byte read next must still show the flag set.

// File: rtl/shr_pkg.sv
package shr_pkg;
   localparam int BUS_W = 8;
   localparam int NIB_W = 4;
   localparam int NCH   = 3;

   typedef enum logic [1:0] {
      CH_STATUS = 2'b00,
      CH_X      = 2'b01,
      CH_Y      = 2'b10,
      CH_Z      = 2'b11
   } chan_e;

   typedef enum logic [1:0] {
      OFS_CTRL = 2'd0,
      OFS_PAR  = 2'd1,
      OFS_MEM  = 2'd2,
      OFS_CMD  = 2'd3
   } ofs_e;

   typedef struct packed {
      logic       irq_en;
      logic [3:0] led;
      chan_e      chan;
   } cmd_t;
endpackage

// File: rtl/shr_capture.sv
module shr_capture #(
   parameter int NCH   = 3,
   parameter int CNT_W = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 copy_req,
   input  logic                 busy,
   input  logic [NCH*CNT_W-1:0] live_all,
   output logic [NCH*CNT_W-1:0] hold_all,
   output logic                 pending
);
   logic want;
   logic take;

   assign want = copy_req | pending;
   assign take = want & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= want & busy;
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_all[ch*CNT_W +: CNT_W] <= '0;
         else if (take)
            hold_all[ch*CNT_W +: CNT_W] <= live_all[ch*CNT_W +: CNT_W];
      end
   end
endmodule

// File: rtl/shr_cmd.sv
module shr_cmd
   import shr_pkg::*;
#(
   parameter int PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic             cmd_clr,
   input  logic [7:0]       wdata,
   input  logic             ptr_step,
   input  logic             sw_event,
   input  logic             flag_clr,
   output cmd_t             cmd_q,
   output logic [PTR_W-1:0] ptr_q,
   output logic             flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         ptr_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (cmd_clr) begin
            cmd_q <= '0;
         end else if (cmd_wr) begin
            cmd_q.irq_en <= wdata[7];
            cmd_q.led    <= wdata[6:3];
            cmd_q.chan   <= chan_e'(wdata[1:0]);
         end

         if (cmd_clr || cmd_wr) ptr_q <= '0;
         else if (ptr_step)     ptr_q <= ptr_q + 1'b1;

         if (sw_event)      flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/shr_mem.sv
module shr_mem #(
   parameter int DEPTH  = 64,
   parameter int PTR_W  = 6,
   parameter bit MEM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] ptr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);
   if (MEM_EN) begin : g_ram
      logic [7:0] ram [DEPTH];
      always_ff @(posedge clk) begin
         if (we) ram[ptr] <= wdata;
      end
      assign rdata = ram[ptr];
   end else begin : g_none
      assign rdata = '0;
   end
endmodule

// File: rtl/snapshot_host_regs.sv
module snapshot_host_regs
   import shr_pkg::*;
#(
   parameter int DIGITS    = 6,
   parameter int MEM_DEPTH = 64,
   parameter bit MEM_EN    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              bus_addr_i,
   input  logic                    bus_wr_i,
   input  logic                    bus_rd_i,
   input  logic [7:0]              bus_wdata_i,
   output logic [7:0]              bus_rdata_o,
   input  logic [DIGITS*4-1:0]     cnt_x_i,
   input  logic [DIGITS*4-1:0]     cnt_y_i,
   input  logic [DIGITS*4-1:0]     cnt_z_i,
   input  logic                    cnt_busy_i,
   input  logic                    rate_err_i,
   input  logic                    sw_event_i,
   input  logic [7:0]              par_in_i,
   output logic [7:0]              par_out_o,
   output logic [3:0]              led_o,
   output logic                    irq_o,
   output logic                    cnt_clear_o
);
   localparam int CNT_W = DIGITS * NIB_W;
   localparam int PTR_W = $clog2(MEM_DEPTH);

   if (DIGITS < 1 || DIGITS > 15) begin : g_bad_digits
      $error("DIGITS must lie in 1..15");
   end
   if ((1 << PTR_W) != MEM_DEPTH || MEM_DEPTH <= DIGITS) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two larger than DIGITS");
   end

   // access decode
   logic rd_ctrl, rd_par, rd_mem, rd_cmd;
   logic wr_ctrl, wr_par, wr_mem, wr_cmd;
   assign rd_ctrl = bus_rd_i && (bus_addr_i == OFS_CTRL);
   assign rd_par  = bus_rd_i && (bus_addr_i == OFS_PAR);
   assign rd_mem  = bus_rd_i && (bus_addr_i == OFS_MEM);
   assign rd_cmd  = bus_rd_i && (bus_addr_i == OFS_CMD);
   assign wr_ctrl = bus_wr_i && (bus_addr_i == OFS_CTRL);
   assign wr_par  = bus_wr_i && (bus_addr_i == OFS_PAR);
   assign wr_mem  = bus_wr_i && (bus_addr_i == OFS_MEM);
   assign wr_cmd  = bus_wr_i && (bus_addr_i == OFS_CMD);

   logic copy_req, clr_req;
   assign copy_req = wr_ctrl &  bus_wdata_i[0];
   assign clr_req  = wr_ctrl & ~bus_wdata_i[0];

   // snapshot store
   logic [NCH*CNT_W-1:0] live_all;
   logic [NCH*CNT_W-1:0] hold_all;
   logic                 pending;
   assign live_all = {cnt_z_i, cnt_y_i, cnt_x_i};

   shr_capture #(.NCH(NCH), .CNT_W(CNT_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .copy_req (copy_req),
      .busy     (cnt_busy_i),
      .live_all (live_all),
      .hold_all (hold_all),
      .pending  (pending)
   );

   // command, pointer, flag
   cmd_t             cmd_q;
   logic [PTR_W-1:0] ptr_q;
   logic             flag_q;
   logic             digit_rd;
   logic             ptr_step;

   assign digit_rd = rd_ctrl && (cmd_q.chan != CH_STATUS);
   assign ptr_step = digit_rd || rd_mem || wr_mem;

   shr_cmd #(.PTR_W(PTR_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (wr_cmd),
      .cmd_clr  (clr_req),
      .wdata    (bus_wdata_i),
      .ptr_step (ptr_step),
      .sw_event (sw_event_i),
      .flag_clr (rd_cmd),
      .cmd_q    (cmd_q),
      .ptr_q    (ptr_q),
      .flag_q   (flag_q)
   );

   // scratch memory
   logic [7:0] mem_rdata;
   shr_mem #(.DEPTH(MEM_DEPTH), .PTR_W(PTR_W), .MEM_EN(MEM_EN)) u_mem (
      .clk   (clk),
      .we    (wr_mem),
      .ptr   (ptr_q),
      .wdata (bus_wdata_i),
      .rdata (mem_rdata)
   );

   // parallel output latch and clear pulse
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_out_o   <= '0;
         cnt_clear_o <= 1'b0;
      end else begin
         if (wr_par) par_out_o <= bus_wdata_i;
         cnt_clear_o <= clr_req;
      end
   end

   // digit selection
   logic [CNT_W-1:0] sel_word;
   logic [3:0]       digit;

   always_comb begin
      case (cmd_q.chan)
         CH_X:    sel_word = hold_all[0*CNT_W +: CNT_W];
         CH_Y:    sel_word = hold_all[1*CNT_W +: CNT_W];
         CH_Z:    sel_word = hold_all[2*CNT_W +: CNT_W];
         default: sel_word = '0;
      endcase
   end

   always_comb begin
      digit = '0;
      for (int d = 0; d < DIGITS; d++) begin
         if (ptr_q == PTR_W'(d)) digit = sel_word[(DIGITS-1-d)*NIB_W +: NIB_W];
      end
   end

   // read data
   logic [7:0] ctrl_byte;
   always_comb begin
      if (cmd_q.chan == CH_STATUS) ctrl_byte = {flag_q, rate_err_i, 2'b00, 4'hF};
      else                         ctrl_byte = {4'h0, digit};
   end

   always_comb begin
      case (bus_addr_i)
         OFS_CTRL: bus_rdata_o = ctrl_byte;
         OFS_PAR:  bus_rdata_o = par_in_i;
         OFS_MEM:  bus_rdata_o = mem_rdata;
         default:  bus_rdata_o = 8'hFF;
      endcase
   end

   assign led_o = cmd_q.led;
   assign irq_o = flag_q & cmd_q.irq_en;
endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
   parameter int CNT_W = 24,
   parameter int PTR_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         bus_addr_i,
   input logic               bus_wr_i,
   input logic               bus_rd_i,
   input logic [7:0]         bus_wdata_i,
   input logic [7:0]         bus_rdata_o,
   input logic               cnt_busy_i,
   input logic               sw_event_i,
   input logic               cnt_clear_o,
   input logic [3*CNT_W-1:0] hold_all,
   input logic               pending,
   input logic [PTR_W-1:0]   ptr_q,
   input logic               flag_q,
   input logic [1:0]         chan
);
   AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == 2'd0 && !bus_wdata_i[0]) |=> cnt_clear_o); // R1

   AST_COPY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold_all) |-> $past(!cnt_busy_i)); // R2

   AST_DIGIT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == 2'd0 && chan != 2'd0) |-> (bus_rdata_o[7:4] == 4'h0)); // R4

   AST_STATUS_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == 2'd0 && chan == 2'd0) |-> (bus_rdata_o[3:0] == 4'hF)); // R5

   AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == 2'd3) |=> (ptr_q == '0)); // R6

   AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == 2'd3 && !sw_event_i) |=> !flag_q); // R8

   AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !cnt_busy_i) |=> !pending); // R9
endmodule

bind snapshot_host_regs shr_checker #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .cnt_busy_i  (cnt_busy_i),
   .sw_event_i  (sw_event_i),
   .cnt_clear_o (cnt_clear_o),
   .hold_all    (hold_all),
   .pending     (pending),
   .ptr_q       (ptr_q),
   .flag_q      (flag_q),
   .chan        (cmd_q.chan)
);

// File: tb/snapshot_host_regs_test.sv
module snapshot_host_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] cx = '0, cy = '0, cz = '0;
   logic        busy = 1'b0;
   logic        rerr = 1'b0;
   logic        sw = 1'b0;
   logic [7:0]  pin = '0;
   logic [7:0]  pout;
   logic [3:0]  led;
   logic        irq;
   logic        cclr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   snapshot_host_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
      .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .cnt_x_i(cx), .cnt_y_i(cy), .cnt_z_i(cz), .cnt_busy_i(busy),
      .rate_err_i(rerr), .sw_event_i(sw), .par_in_i(pin), .par_out_o(pout),
      .led_o(led), .irq_o(irq), .cnt_clear_o(cclr)
   );

   // counter sets {X, Y, Z} in BCD
   localparam logic [23:0] VEC [4][3] = '{
      '{24'h123456, 24'h000001, 24'h999999},
      '{24'h000000, 24'h987654, 24'h500005},
      '{24'h090807, 24'h654321, 24'h000010},
      '{24'h777777, 24'h102938, 24'h246800}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      logic [7:0] got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R1 reset clear", {31'd0, cclr}, 0);
      check("R3 reset led", {28'd0, led}, 0);
      check("R3 reset irq", {31'd0, irq}, 0);
      check("R7 reset par_out", {24'd0, pout}, 0);
      rd(2'd0, got);
      check("R5 reset status", {24'd0, got}, 32'h0F);

      // vector table walk: copy, then read every channel and one digit past the end
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         cx = VEC[v][0]; cy = VEC[v][1]; cz = VEC[v][2];
         wr(2'd0, 8'h01);
         for (int ch = 1; ch <= 3; ch++) begin
            wr(2'd3, 8'(ch));
            for (int d = 0; d < 7; d++) begin
               logic [7:0] exp;
               rd(2'd0, got);
               exp = (d < 6) ? {4'h0, VEC[v][ch-1][(5-d)*4 +: 4]} : 8'h00;
               check(d < 6 ? "R4 digit" : "R4 past end", {24'd0, got}, {24'd0, exp});
            end
         end
      end

      // R2: snapshot unaffected by later counter motion
      @(negedge clk);
      cx = 24'h111111;
      wr(2'd0, 8'h01);
      cx = 24'h424242;
      wr(2'd3, 8'h01);
      rd(2'd0, got);
      check("R2 held after change", {24'd0, got}, 32'h01);

      // R9: deferred copy while busy, values taken at first idle cycle
      @(negedge clk);
      busy = 1'b1;
      cx = 24'h222222;
      wr(2'd0, 8'h01);
      wr(2'd3, 8'h01);
      rd(2'd0, got);
      check("R9 no capture while busy", {24'd0, got}, 32'h01);
      @(negedge clk);
      cx = 24'h333333;
      @(negedge clk);
      busy = 1'b0;
      @(negedge clk);
      cx = 24'h444444;
      wr(2'd3, 8'h01);
      rd(2'd0, got);
      check("R9 deferred capture", {24'd0, got}, 32'h03);

      // R3: command fields, irq gating
      wr(2'd3, 8'b1101_0100);
      check("R3 led map", {28'd0, led}, 32'hA);
      check("R3 irq no flag", {31'd0, irq}, 0);
      @(negedge clk); sw = 1'b1;
      @(negedge clk); sw = 1'b0;
      check("R3 irq flag+en", {31'd0, irq}, 1);
      wr(2'd3, 8'b0101_0000);
      check("R3 irq disabled", {31'd0, irq}, 0);
      rerr = 1'b1;
      rd(2'd0, got);
      check("R5 status flag err", {24'd0, got}, 32'hCF);

      // R8: clear read
      rd(2'd3, got);
      check("R8 clear read value", {24'd0, got}, 32'hFF);
      rd(2'd0, got);
      check("R8 flag cleared", {24'd0, got}, 32'h4F);
      rerr = 1'b0;

      // R8: set and clear in the same cycle
      @(negedge clk);
      sw = 1'b1; bus_addr = 2'd3; bus_rd = 1'b1;
      #1 got = bus_rdata;
      @(negedge clk);
      sw = 1'b0; bus_rd = 1'b0;
      check("R8 coincide read value", {24'd0, got}, 32'hFF);
      rd(2'd0, got);
      check("R8 set wins", {24'd0, got}, 32'h8F);

      // R6 / R10: pointer and scratch memory
      wr(2'd3, 8'h00);
      rd(2'd0, got);
      rd(2'd0, got);
      wr(2'd2, 8'hA5);
      wr(2'd2, 8'h3C);
      wr(2'd3, 8'h00);
      rd(2'd2, got);
      check("R6 R10 mem at 0", {24'd0, got}, 32'hA5);
      rd(2'd2, got);
      check("R6 R10 mem at 1", {24'd0, got}, 32'h3C);

      // R7: parallel ports
      pin = 8'h5A;
      rd(2'd1, got);
      check("R7 par in", {24'd0, got}, 32'h5A);
      wr(2'd1, 8'hC3);
      check("R7 par out", {24'd0, pout}, 32'hC3);
      rd(2'd1, got);
      check("R7 par out held", {24'd0, pout}, 32'hC3);

      // R1: clear command
      wr(2'd3, 8'b1111_1011);
      wr(2'd0, 8'h00);
      check("R1 clear pulse", {31'd0, cclr}, 1);
      check("R1 leds zeroed", {28'd0, led}, 0);
      @(negedge clk);
      check("R1 pulse one cycle", {31'd0, cclr}, 0);
      rd(2'd0, got);
      check("R1 status selected", {24'd0, got}, 32'h8F);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule